// File: doc/BRIEF.md
# Idle-Mode Power Controller

This block decides when the CPU core of a small microcontroller may be clocked. Software asks for idle by writing the power-control register with its idle bit set. The block waits until the writing instruction has retired and then drops the core clock enable. The interrupt, timer, watchdog and serial-port logic keep a running clock enable throughout. While the core is halted, the block also tells the bus logic to hold the address-latch and program-fetch strobes high, and tells the ports to keep their present output levels.

There are two ways out of idle. The first is a pending enabled interrupt. It gives a one-cycle wake pulse, clears the idle bit in hardware and lets the core run its service routine, after which the program continues past the idling instruction. The second is a qualified reset, which puts the core straight into synchronous reset. The external reset pin counts only after it has stayed high for a minimum number of synchronized cycles. Power-fail reset takes effect at once and asynchronously. Watchdog reset takes effect at the next clock edge. Because the core is in reset in the cycle it regains its clock, the instruction that follows the idle write never executes.

The controller is a five-state machine:
- **RUN**: the core executes normally.
- **ARMED**: the idle write has been seen, but the instruction has not yet retired.
- **HALT**: the core clock is gated.
- **WAKE**: a one-cycle interrupt exit.
- **RESET**: the system reset is asserted.

The transitions are:
- **arm**: RUN or WAKE to ARMED.
- **enter**: RUN, WAKE or ARMED to HALT, on retirement.
- **irq_exit**: HALT to WAKE.
- **resume**: WAKE to RUN.
- **rst_hit**: any state to RESET.
- **rst_done**: RESET to RUN.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: A write of the control register with bit 0 = 1 is an idle request. The retire pulse of that write may come in the same cycle or in a later one. When it arrives, the next clock edge makes `idle_flag` 1. A write with bit 0 = 0 never starts idle.
- R2: While halted, `core_clk_en` is 0 and `periph_clk_en` is 1. The core stays halted until an interrupt or a reset arrives.
- R3: `strobe_hold` and `port_hold` are 1 exactly while the core is halted. They fall only on an interrupt wake or a reset.
- R4: In the halted state, `irq_pending` = 1 produces, one edge later, `wake_irq` = 1 for one cycle, `idle_flag` = 0 and `core_clk_en` = 1.
- R5: An external reset pin pulse shorter than 8 cycles has no effect. `sys_rst` stays 0 and a halted core stays halted.
- R6: An external reset pin held high for at least 8 cycles raises `sys_rst` 11 edges after the first edge that samples it high. This count covers 2 synchronizer stages, 8 count cycles and the state register. `sys_rst` stays high while the pin stays high.
- R7: `wdt_rst` raises `sys_rst` at the next edge. `pwr_fail_rst` raises `sys_rst` at once, without a clock edge.
- R8: A reset request in the halted state leads straight to `sys_rst` = 1 with `core_clk_en` = 1, `idle_flag` = 0 and no `wake_irq` pulse.
- R9: `sys_rst` falls one edge after every reset source has gone. The core then runs with `idle_flag` = 0.
- R10: `idle_flag` reads 0 in every state other than halted, including the armed state between the idle write and its retirement.
- R11: `irq_pending` outside the halted state has no effect. `wake_irq` pulses only after a halted cycle with an interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_fail_rst | input | 1 | Power-fail reset, active high, asynchronous |
| wdt_rst | input | 1 | Watchdog reset request, active high |
| ext_rst_pin | input | 1 | External reset pin, asynchronous, active high |
| reg_wr | input | 1 | Power-control register write strobe |
| reg_wdata | input | CTRL_W | Write data (bit IDLE_BIT requests idle) |
| instr_retire | input | 1 | Retire pulse of the instruction in flight |
| irq_pending | input | 1 | An enabled interrupt is pending |
| core_clk_en | output | 1 | CPU core clock enable |
| periph_clk_en | output | 1 | Clock enable for interrupt, timer, watchdog and serial logic |
| idle_flag | output | 1 | Idle bit read-back, 1 only while halted |
| strobe_hold | output | 1 | Force address-latch and fetch strobes high |
| port_hold | output | 1 | Freeze port output levels |
| wake_irq | output | 1 | One-cycle interrupt wake pulse |
| sys_rst | output | 1 | Synchronous system reset |

## Verification
A wrong state register shows up one edge after the stimulus. It appears as a disagreement among `idle_flag`, `core_clk_en`, `wake_irq` and `sys_rst`, which the bench compares every cycle against a model driven by random writes, retirements, interrupts and watchdog hits. A miscounting width filter is visible only at the exact edge where `sys_rst` should or should not rise. The 7-cycle and 8-cycle pin pulses pin that edge down to a single cycle. A wrong exit path shows up as a stray `wake_irq` on a reset exit, or as a held `strobe_hold` after a wake.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_ARMED,
        ST_HALT,
        ST_WAKE,
        ST_RESET
    } pwr_state_e;
endpackage

// File: rtl/rst_width_filter.sv
module rst_width_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CYC     = 8
) (
    input  logic clk,
    input  logic arst,
    input  logic pin,
    output logic valid
);
    localparam int CNT_W = $clog2(MIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_CYC);

    logic             pin_s;
    logic [CNT_W-1:0] cnt_q;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign pin_s = pin;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or posedge arst) begin
                if (arst) begin
                    sync_q <= '0;
                end else begin
                    sync_q[0] <= pin;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        sync_q[i] <= sync_q[i-1];
                    end
                end
            end
            assign pin_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // Width counter: clears on any low sample, saturates at the qualifying width.
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cnt_q <= '0;
        end else if (!pin_s) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign valid = (cnt_q == CNT_MAX);
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
    import idle_pwr_pkg::*;
#(
    parameter int CTRL_W   = 8,
    parameter int IDLE_BIT = 0
) (
    input  logic              clk,
    input  logic              arst,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    input  logic              instr_retire,
    input  logic              irq_pending,
    input  logic              rst_req,
    output logic              core_clk_en,
    output logic              periph_clk_en,
    output logic              idle_flag,
    output logic              strobe_hold,
    output logic              port_hold,
    output logic              wake_irq,
    output logic              sys_rst
);
    pwr_state_e state_q, state_d;
    logic       idle_req;
    logic       unused_wdata;

    assign idle_req     = reg_wr && reg_wdata[IDLE_BIT];
    assign unused_wdata = ^reg_wdata;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (rst_req) begin
            state_d = ST_RESET;                        // rst_hit
        end else begin
            unique case (state_q)
                ST_RUN, ST_WAKE: begin
                    if (idle_req && instr_retire) state_d = ST_HALT;   // enter
                    else if (idle_req)            state_d = ST_ARMED;  // arm
                    else                          state_d = ST_RUN;    // resume
                end
                ST_ARMED: if (instr_retire) state_d = ST_HALT;         // enter
                ST_HALT:  if (irq_pending)  state_d = ST_WAKE;         // irq_exit
                ST_RESET: state_d = ST_RUN;                            // rst_done
                default:  state_d = ST_RESET;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) state_q <= ST_RESET;
        else      state_q <= state_d;
    end

    // Output decode
    always_comb begin
        core_clk_en   = 1'b1;
        periph_clk_en = 1'b1;
        idle_flag     = 1'b0;
        strobe_hold   = 1'b0;
        port_hold     = 1'b0;
        wake_irq      = 1'b0;
        sys_rst       = 1'b0;
        unique case (state_q)
            ST_RUN, ST_ARMED: ;
            ST_HALT: begin
                core_clk_en = 1'b0;
                idle_flag   = 1'b1;
                strobe_hold = 1'b1;
                port_hold   = 1'b1;
            end
            ST_WAKE:  wake_irq = 1'b1;
            ST_RESET: sys_rst  = 1'b1;
            default:  sys_rst  = 1'b1;
        endcase
    end
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl #(
    parameter int CTRL_W      = 8,
    parameter int IDLE_BIT    = 0,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_RST_CYC = 8
) (
    input  logic              clk,
    input  logic              pwr_fail_rst,
    input  logic              wdt_rst,
    input  logic              ext_rst_pin,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    input  logic              instr_retire,
    input  logic              irq_pending,
    output logic              core_clk_en,
    output logic              periph_clk_en,
    output logic              idle_flag,
    output logic              strobe_hold,
    output logic              port_hold,
    output logic              wake_irq,
    output logic              sys_rst
);
    logic ext_ok;
    logic rst_req;

    rst_width_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_CYC     (MIN_RST_CYC)
    ) u_filt (
        .clk   (clk),
        .arst  (pwr_fail_rst),
        .pin   (ext_rst_pin),
        .valid (ext_ok)
    );

    assign rst_req = ext_ok || wdt_rst;

    idle_fsm #(
        .CTRL_W   (CTRL_W),
        .IDLE_BIT (IDLE_BIT)
    ) u_fsm (
        .clk           (clk),
        .arst          (pwr_fail_rst),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .instr_retire  (instr_retire),
        .irq_pending   (irq_pending),
        .rst_req       (rst_req),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .idle_flag     (idle_flag),
        .strobe_hold   (strobe_hold),
        .port_hold     (port_hold),
        .wake_irq      (wake_irq),
        .sys_rst       (sys_rst)
    );
endmodule

// File: rtl/idle_pwr_chk.sv
module idle_pwr_chk #(
    parameter int CTRL_W   = 8,
    parameter int IDLE_BIT = 0
) (
    input logic              clk,
    input logic              pwr_fail_rst,
    input logic              wdt_rst,
    input logic              ext_ok,
    input logic              reg_wr,
    input logic [CTRL_W-1:0] reg_wdata,
    input logic              instr_retire,
    input logic              irq_pending,
    input logic              core_clk_en,
    input logic              idle_flag,
    input logic              strobe_hold,
    input logic              wake_irq,
    input logic              sys_rst
);
    assert_idle_entry_R1: assert property (@(posedge clk) disable iff (pwr_fail_rst)
        (!idle_flag && !sys_rst && reg_wr && reg_wdata[IDLE_BIT] && instr_retire
         && !ext_ok && !wdt_rst) |=> idle_flag);

    assert_halt_holds_R2: assert property (@(posedge clk) disable iff (pwr_fail_rst)
        (idle_flag && !ext_ok && !wdt_rst && !irq_pending) |=> (idle_flag && !core_clk_en));

    assert_strobe_release_R3: assert property (@(posedge clk) disable iff (pwr_fail_rst)
        $fell(strobe_hold) |-> (wake_irq || sys_rst));

    assert_irq_wake_R4: assert property (@(posedge clk) disable iff (pwr_fail_rst)
        (idle_flag && irq_pending && !ext_ok && !wdt_rst) |=> (wake_irq && !idle_flag && core_clk_en));

    assert_wdt_reset_R7: assert property (@(posedge clk) disable iff (pwr_fail_rst)
        wdt_rst |=> sys_rst);

    assert_reset_exit_R8: assert property (@(posedge clk) disable iff (pwr_fail_rst)
        (idle_flag && (ext_ok || wdt_rst)) |=> (sys_rst && core_clk_en && !wake_irq));

    assert_reset_release_R9: assert property (@(posedge clk) disable iff (pwr_fail_rst)
        (sys_rst && !ext_ok && !wdt_rst) |=> (!sys_rst && !idle_flag));

    assert_wake_source_R11: assert property (@(posedge clk) disable iff (pwr_fail_rst)
        wake_irq |-> ($past(idle_flag) && $past(irq_pending)));
endmodule

bind idle_pwr_ctrl idle_pwr_chk #(
    .CTRL_W   (CTRL_W),
    .IDLE_BIT (IDLE_BIT)
) u_chk (
    .clk          (clk),
    .pwr_fail_rst (pwr_fail_rst),
    .wdt_rst      (wdt_rst),
    .ext_ok       (ext_ok),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .instr_retire (instr_retire),
    .irq_pending  (irq_pending),
    .core_clk_en  (core_clk_en),
    .idle_flag    (idle_flag),
    .strobe_hold  (strobe_hold),
    .wake_irq     (wake_irq),
    .sys_rst      (sys_rst)
);

// File: tb/sim_idle_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_idle_pwr_ctrl;
    logic       clk = 1'b0;
    logic       pwr_fail_rst, wdt_rst, ext_rst_pin, reg_wr, instr_retire, irq_pending;
    logic [7:0] reg_wdata;
    logic       core_clk_en, periph_clk_en, idle_flag, strobe_hold, port_hold, wake_irq, sys_rst;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    idle_pwr_ctrl u0 (
        .clk(clk), .pwr_fail_rst(pwr_fail_rst), .wdt_rst(wdt_rst), .ext_rst_pin(ext_rst_pin),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .instr_retire(instr_retire),
        .irq_pending(irq_pending), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .idle_flag(idle_flag), .strobe_hold(strobe_hold), .port_hold(port_hold),
        .wake_irq(wake_irq), .sys_rst(sys_rst)
    );

    // Model states: 0 run, 1 armed, 2 halted, 3 wake, 4 reset
    function automatic int model_next(int s, logic wr, logic d0, logic ret, logic irq, logic rq);
        if (rq) return 4;
        case (s)
            0, 3: return (wr && d0 && ret) ? 2 : ((wr && d0) ? 1 : 0);
            1:    return ret ? 2 : 1;
            2:    return irq ? 3 : 2;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int s_exp;
        void'($urandom(32'h1D1E5EED));
        pwr_fail_rst = 1'b1; wdt_rst = 1'b0; ext_rst_pin = 1'b0; reg_wr = 1'b0;
        reg_wdata = 8'h00; instr_retire = 1'b0; irq_pending = 1'b0;
        #1;
        chk("R7 power-fail sys_rst at once", sys_rst, 1'b1);
        repeat (3) cyc();
        chk("R9 reset state idle_flag", idle_flag, 1'b0);
        chk("R2 reset state periph_clk_en", periph_clk_en, 1'b1);
        pwr_fail_rst = 1'b0;
        cyc();
        chk("R9 sys_rst released", sys_rst, 1'b0);
        chk("R9 core_clk_en after release", core_clk_en, 1'b1);

        // Idle request, retirement one cycle later
        reg_wr = 1'b1; reg_wdata = 8'h01;
        cyc();
        reg_wr = 1'b0;
        chk("R10 armed idle_flag", idle_flag, 1'b0);
        chk("R10 armed core_clk_en", core_clk_en, 1'b1);
        instr_retire = 1'b1;
        cyc();
        instr_retire = 1'b0;
        chk("R1 idle_flag after retire", idle_flag, 1'b1);
        chk("R2 core_clk_en halted", core_clk_en, 1'b0);
        chk("R2 periph_clk_en halted", periph_clk_en, 1'b1);
        chk("R3 strobe_hold halted", strobe_hold, 1'b1);
        chk("R3 port_hold halted", port_hold, 1'b1);
        repeat (3) cyc();
        chk("R2 still halted", idle_flag, 1'b1);

        // 7-cycle pin pulse: ignored
        ext_rst_pin = 1'b1;
        repeat (7) cyc();
        ext_rst_pin = 1'b0;
        for (int i = 0; i < 6; i++) begin
            cyc();
            chk("R5 short pulse sys_rst", sys_rst, 1'b0);
            chk("R5 short pulse keeps halt", idle_flag, 1'b1);
        end

        // Interrupt wake
        irq_pending = 1'b1;
        cyc();
        irq_pending = 1'b0;
        chk("R4 wake_irq", wake_irq, 1'b1);
        chk("R4 idle_flag cleared", idle_flag, 1'b0);
        chk("R4 core_clk_en", core_clk_en, 1'b1);
        chk("R3 strobe_hold released", strobe_hold, 1'b0);
        cyc();
        chk("R4 wake one cycle", wake_irq, 1'b0);

        // Interrupt while running
        irq_pending = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R11 no wake when running", wake_irq, 1'b0);
        end
        irq_pending = 1'b0;

        // Write with idle bit clear
        reg_wr = 1'b1; reg_wdata = 8'hFE; instr_retire = 1'b1;
        cyc();
        chk("R1 bit0=0 no idle", idle_flag, 1'b0);
        cyc();
        chk("R1 bit0=0 no idle later", idle_flag, 1'b0);
        reg_wdata = 8'h01;
        cyc();
        reg_wr = 1'b0; instr_retire = 1'b0;
        chk("R1 same-cycle retire idle", idle_flag, 1'b1);

        // 8-cycle pin pulse while halted
        ext_rst_pin = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            cyc();
            chk("R6 no early reset", sys_rst, 1'b0);
        end
        ext_rst_pin = 1'b0;
        cyc();
        chk("R6 no reset at edge 9", sys_rst, 1'b0);
        cyc();
        chk("R6 no reset at edge 10", sys_rst, 1'b0);
        chk("R6 halted until reset", idle_flag, 1'b1);
        cyc();
        chk("R6 reset at edge 11", sys_rst, 1'b1);
        chk("R8 idle cleared on reset", idle_flag, 1'b0);
        chk("R8 no wake on reset", wake_irq, 1'b0);
        chk("R8 core_clk_en on reset", core_clk_en, 1'b1);
        cyc();
        chk("R9 reset ends", sys_rst, 1'b0);
        chk("R9 running after reset", idle_flag, 1'b0);

        // Long pin hold
        ext_rst_pin = 1'b1;
        repeat (20) cyc();
        chk("R6 long hold sys_rst", sys_rst, 1'b1);
        ext_rst_pin = 1'b0;
        repeat (4) cyc();
        chk("R9 long hold release", sys_rst, 1'b0);
        chk("R9 long hold idle_flag", idle_flag, 1'b0);

        // Watchdog reset
        wdt_rst = 1'b1;
        cyc();
        wdt_rst = 1'b0;
        chk("R7 watchdog sys_rst", sys_rst, 1'b1);
        cyc();
        chk("R9 watchdog release", sys_rst, 1'b0);

        // Asynchronous power-fail mid-cycle
        #0.5;
        pwr_fail_rst = 1'b1;
        #0.5;
        chk("R7 power-fail async", sys_rst, 1'b1);
        cyc();
        pwr_fail_rst = 1'b0;
        cyc();
        chk("R9 power-fail release", sys_rst, 1'b0);

        // Random phase against the model
        s_exp = 0;
        for (int k = 0; k < 3000; k++) begin
            reg_wr       = ($urandom % 4) == 0;
            reg_wdata    = 8'($urandom);
            instr_retire = ($urandom % 3) == 0;
            irq_pending  = ($urandom % 6) == 0;
            wdt_rst      = ($urandom % 64) == 0;
            s_exp = model_next(s_exp, reg_wr, reg_wdata[0], instr_retire, irq_pending, wdt_rst);
            cyc();
            chk("R10 random idle_flag", idle_flag, s_exp == 2);
            chk("R2 random core_clk_en", core_clk_en, s_exp != 2);
            chk("R4 random wake_irq", wake_irq, s_exp == 3);
            chk("R7 random sys_rst", sys_rst, s_exp == 4);
        end
        finish_run();
    end
endmodule